// File: doc/BRIEF.md
# I2C Register-Pointer Slave Front End

This block is the serial front end of a 16-bit port expander with eight byte-wide registers. It runs from a fast system clock and oversamples the two-wire bus. Each line passes through a short synchronizer, and the block decodes START and STOP conditions, bit timing and acknowledge slots from the sampled levels. It answers a 7-bit address that combines a fixed upper nibble with three strap pins.

In a write transfer, the first byte after the address is a command byte. Its low three bits load a register pointer. Each following data byte is handed to the register side as a one-cycle write strobe that carries the pointer and the byte. For a read, the master first sets the pointer with a write, then issues a repeated START and the read address. The block then asks the register side for the byte at the pointer and shifts it out. After every data byte, in either direction, the pointer moves to the other register of its pair by flipping bit 0. The pointer is kept across transfers. A separate pulse marks each read fetch from the input-port pair, so the register side can latch the pin levels at that moment.

The SCL high and low phases must each last several system clocks. Three clocks of latency sit between a bus edge and the block's response to it.

Top module: `i2c_regptr_slave`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal binary 0100 followed by strap[2:0] (strap[2] most significant). It acknowledges by pulling SDA low during the ninth clock. On a mismatch it pulls SDA low for no bit of that transfer until the next START.
- R2: The first byte after a write address is acknowledged and sets the pointer to its bits [2:0]. Bits [7:3] of that byte are ignored.
- R3: Every data byte in a write transfer is acknowledged. On the falling edge of its acknowledge clock, regWrEn pulses for one cycle, with regWrAddr equal to the pointer and regWrData equal to the byte, received MSB first. regWrEn and regRdReq are never high together.
- R4: After each data byte, written or read, the pointer flips its bit 0. A transfer may carry any number of data bytes.
- R5: After an address with R/W=1 (bit 0 of the address byte equal to 1), regRdReq pulses for one cycle with regRdAddr equal to the pointer. regRdData is sampled in that same cycle and shifted out MSB first. The block changes its SDA drive only while SCL is low.
- R6: When the master acknowledges a read byte, the next register of the pair is fetched and sent. When the master does not acknowledge, the block releases SDA and issues no further read request before the next START.
- R7: The pointer persists across transfers. A read that is not preceded by a command byte starts at the stored pointer.
- R8: A START or STOP at any bit position returns the block to address reception, with no write strobe for a partial byte. A STOP releases SDA.
- R9: inCapture pulses together with regRdReq exactly when regRdAddr is 0 or 1.
- R10: After reset, sdaDriveLow, regWrEn and regRdReq are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 3 | Low three address bits |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 3 | Register index for the write |
| regWrData | output | 8 | Byte to write |
| regRdReq | output | 1 | One-cycle register read request |
| regRdAddr | output | 3 | Register index for the read |
| regRdData | input | 8 | Byte returned combinationally for regRdAddr |
| inCapture | output | 1 | Pulse when an input-port register is fetched |

## Verification
Each bus edge reaches the control logic three clock edges after the master moves SCL: two synchronizer flops, then the edge-detect compare, then the output register. So the acknowledge drive, each read bit and both strobes settle about three cycles after SCL falls. The bench master holds each SCL phase for twenty cycles and samples SDA in the middle of the high phase, well after that settling point. Write and read strobes arrive at times that depend on bus timing, so the bench does not count cycles for them. The driver queues the expected address and data before sending each byte. A monitor then compares every strobe on the falling clock edge, which makes the order of strobes the thing checked, independent of their exact cycle.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } busState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrBits;   // bit counter to zero
    logic rxShift;   // shift SDA into receive byte, count bit
    logic txCount;   // count a transmit clock
    logic txShift;   // present next transmit bit
    logic ackDrive;  // pull SDA low for acknowledge
    logic sdaFree;   // release SDA
    logic loadPtr;   // pointer from command byte
    logic loadTx;    // fetch register byte and present its MSB
    logic commit;    // write strobe for the received byte
  } ctlStrobe_t;

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncOut;
  logic             sclD, sdaD;

  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '1;
        else       pipe <= rawIn[g];
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipe[STAGES-1];
  end

  assign sclS = syncOut[1];
  assign sdaS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

endmodule

// File: rtl/i2c_rp_dp.sv
module i2c_rp_dp
  import i2c_rp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              sdaS,
  input  logic [DATA_W-1:0] regRdData,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [DATA_W-1:0] shiftByte,
  output logic [PTR_W-1:0]  ptr,
  output logic              sdaLow
);

  localparam logic [PTR_W-1:0] PTR_FLIP = PTR_W'(1);

  logic [DATA_W-1:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftByte <= '0;
      txReg     <= '0;
      ptr       <= '0;
      sdaLow    <= 1'b0;
    end else begin
      if (stb.clrBits)
        bitCnt <= '0;
      else if (stb.rxShift || stb.txCount)
        bitCnt <= bitCnt + 1'b1;

      if (stb.rxShift)
        shiftByte <= {shiftByte[DATA_W-2:0], sdaS};

      if (stb.loadTx)
        txReg <= regRdData;
      else if (stb.txShift)
        txReg <= {txReg[DATA_W-2:0], 1'b0};

      if (stb.loadTx)
        sdaLow <= ~regRdData[DATA_W-1];
      else if (stb.txShift)
        sdaLow <= ~txReg[DATA_W-2];
      else if (stb.ackDrive)
        sdaLow <= 1'b1;
      else if (stb.sdaFree)
        sdaLow <= 1'b0;

      if (stb.loadPtr)
        ptr <= shiftByte[PTR_W-1:0];
      else if (stb.commit || stb.loadTx)
        ptr <= ptr ^ PTR_FLIP;
    end
  end

endmodule

// File: rtl/i2c_rp_ctrl.sv
module i2c_rp_ctrl
  import i2c_rp_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          STRAP_W     = 3,
  parameter int          CNT_W       = 4,
  parameter logic [3:0]  ADDR_PREFIX = 4'b0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic               sdaS,
  input  logic [CNT_W-1:0]   bitCnt,
  input  logic [DATA_W-1:0]  shiftByte,
  input  logic [STRAP_W-1:0] strap,
  output ctlStrobe_t         stb
);

  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_POST = CNT_W'(DATA_W + 1);

  busState_e state, stateN;
  logic      inAck, inAckN;
  logic      rwBit, rwN;
  logic      nackSeen, nackN;
  logic      addrHit;

  assign addrHit = (shiftByte[DATA_W-1:1] == {ADDR_PREFIX, strap});

  always_comb begin
    stb    = '0;
    stateN = state;
    inAckN = inAck;
    rwN    = rwBit;
    nackN  = nackSeen;
    if (startDet) begin
      stateN      = ST_ADDR;
      stb.clrBits = 1'b1;
      stb.sdaFree = 1'b1;
      inAckN      = 1'b0;
    end else if (stopDet) begin
      stateN      = ST_IDLE;
      stb.clrBits = 1'b1;
      stb.sdaFree = 1'b1;
      inAckN      = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (sclRise && bitCnt < CNT_ACK) begin
            stb.rxShift = 1'b1;
          end else if (sclFall && inAck) begin
            stb.sdaFree = 1'b1;
            stb.clrBits = 1'b1;
            inAckN      = 1'b0;
            case (state)
              ST_ADDR: begin
                if (rwBit) begin
                  stb.loadTx = 1'b1;
                  stateN     = ST_RDATA;
                end else begin
                  stateN = ST_CMD;
                end
              end
              ST_CMD:  stateN = ST_WDATA;
              default: stb.commit = 1'b1;
            endcase
          end else if (sclFall && bitCnt == CNT_ACK) begin
            if (state == ST_ADDR && !addrHit) begin
              stateN      = ST_IGNORE;
              stb.sdaFree = 1'b1;
            end else begin
              stb.ackDrive = 1'b1;
              inAckN       = 1'b1;
              if (state == ST_ADDR) rwN = shiftByte[0];
              if (state == ST_CMD)  stb.loadPtr = 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            if (bitCnt == CNT_ACK) nackN = sdaS;
            if (bitCnt <= CNT_ACK) stb.txCount = 1'b1;
          end else if (sclFall) begin
            if (bitCnt == CNT_ACK) begin
              stb.sdaFree = 1'b1;
            end else if (bitCnt == CNT_POST) begin
              stb.clrBits = 1'b1;
              if (nackSeen) begin
                stateN      = ST_IGNORE;
                stb.sdaFree = 1'b1;
              end else begin
                stb.loadTx = 1'b1;
              end
            end else if (bitCnt != '0) begin
              stb.txShift = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      inAck    <= 1'b0;
      rwBit    <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      state    <= stateN;
      inAck    <= inAckN;
      rwBit    <= rwN;
      nackSeen <= nackN;
    end
  end

endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_rp_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         PTR_W       = 3,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         INPUT_PAIR  = 0,
  parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDriveLow,
  input  logic [STRAP_W-1:0] strap,
  output logic               regWrEn,
  output logic [PTR_W-1:0]   regWrAddr,
  output logic [DATA_W-1:0]  regWrData,
  output logic               regRdReq,
  output logic [PTR_W-1:0]   regRdAddr,
  input  logic [DATA_W-1:0]  regRdData,
  output logic               inCapture
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  logic              sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftByte;
  logic [PTR_W-1:0]  ptr;
  logic              sdaLow;
  ctlStrobe_t        stb;

  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_rp_ctrl #(
    .DATA_W(DATA_W), .STRAP_W(STRAP_W), .CNT_W(CNT_W), .ADDR_PREFIX(ADDR_PREFIX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .bitCnt(bitCnt),
    .shiftByte(shiftByte), .strap(strap), .stb(stb)
  );

  i2c_rp_dp #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS), .regRdData(regRdData),
    .bitCnt(bitCnt), .shiftByte(shiftByte), .ptr(ptr), .sdaLow(sdaLow)
  );

  assign sdaDriveLow = sdaLow;
  assign regWrEn     = stb.commit;
  assign regWrAddr   = ptr;
  assign regWrData   = shiftByte;
  assign regRdReq    = stb.loadTx;
  assign regRdAddr   = ptr;
  assign inCapture   = stb.loadTx && (ptr[PTR_W-1:1] == (PTR_W-1)'(INPUT_PAIR));

endmodule

// File: rtl/i2c_rp_checker.sv
module i2c_rp_checker #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclSync,
  input logic             stopDet,
  input logic             sdaDriveLow,
  input logic             regWrEn,
  input logic [PTR_W-1:0] regWrAddr,
  input logic             regRdReq,
  input logic [PTR_W-1:0] regRdAddr,
  input logic [PTR_W-1:0] ptrQ
);

  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(regWrEn && regRdReq)); // R3
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN) regWrEn |=> !regWrEn); // R3
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN) regRdReq |=> !regRdReq); // R5
  AST_PTR_FLIP_WR: assert property (@(posedge clk) disable iff (!rstN) regWrEn |=> (ptrQ == ($past(regWrAddr) ^ PTR_ONE))); // R4
  AST_PTR_FLIP_RD: assert property (@(posedge clk) disable iff (!rstN) regRdReq |=> (ptrQ == ($past(regRdAddr) ^ PTR_ONE))); // R4
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN) $rose(sdaDriveLow) |-> !sclSync); // R5
  AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rstN) stopDet |=> !sdaDriveLow); // R8

endmodule

bind i2c_regptr_slave i2c_rp_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclS), .stopDet(stopDet),
  .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
  .regRdReq(regRdReq), .regRdAddr(regRdAddr), .ptrQ(ptr)
);

// File: tb/tb_i2c_regptr_slave.sv
`timescale 1ns/1ps
module tb_i2c_regptr_slave;

  localparam int H = 20;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sdaDriveLow, regWrEn, regRdReq, inCapture;
  logic [2:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;
  wire        sdaBus = mSda & ~sdaDriveLow;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [10:0] expWrQ[$];
  logic [2:0]  expRdQ[$];

  always #4 clk = ~clk;

  function automatic logic [7:0] rdMem(input logic [2:0] a);
    return 8'h3C + 8'(a) * 8'd17;
  endfunction

  assign regRdData = rdMem(regRdAddr);

  i2c_regptr_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .strap(strap),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdReq(regRdReq), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .inCapture(inCapture)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        if (expWrQ.size() == 0)
          chk(1'b0, "R3 unexpected write", {5'd0, regWrAddr, regWrData}, 16'h0);
        else begin
          logic [10:0] e;
          e = expWrQ.pop_front();
          chk({regWrAddr, regWrData} == e, "R3 R4 write addr/data", {5'd0, regWrAddr, regWrData}, {5'd0, e});
        end
      end
      if (regRdReq) begin
        if (expRdQ.size() == 0)
          chk(1'b0, "R6 unexpected read request", {13'd0, regRdAddr}, 16'h0);
        else begin
          logic [2:0] a;
          a = expRdQ.pop_front();
          chk(regRdAddr == a, "R5 R4 read addr", {13'd0, regRdAddr}, {13'd0, a});
          chk(inCapture == (a < 3'd2), "R9 capture pulse", {15'd0, inCapture}, {15'd0, a < 3'd2});
        end
      end else if (inCapture) begin
        chk(1'b0, "R9 capture without read", 16'h1, 16'h0);
      end
    end
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitq(Q);
    mScl = 1'b1; waitq(H);
    mSda = 1'b0; waitq(H);
    mScl = 1'b0; waitq(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitq(Q);
    mScl = 1'b1; waitq(H);
    mSda = 1'b1; waitq(H);
  endtask

  task automatic writeBit(input logic b);
    mSda = b;    waitq(H);
    mScl = 1'b1; waitq(H);
    mScl = 1'b0; waitq(Q);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; waitq(H);
    mScl = 1'b1; waitq(H/2);
    b = sdaBus;  waitq(H/2);
    mScl = 1'b0; waitq(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(output logic [7:0] d, input bit ackIt);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      readBit(b);
      d[i] = b;
    end
    writeBit(ackIt ? 1'b0 : 1'b1);
  endtask

  logic [6:0] dev;
  bit         ack;
  logic [7:0] rd;

  initial begin
    waitq(5);
    chk(sdaDriveLow == 1'b0, "R10 reset sda", {15'd0, sdaDriveLow}, 16'h0);
    chk(regWrEn == 1'b0 && regRdReq == 1'b0, "R10 reset strobes", {14'd0, regWrEn, regRdReq}, 16'h0);
    rstN = 1'b1;
    waitq(10);
    dev = {4'b0100, strap};

    // read straight after reset: pointer 0 (R10, R7)
    busStart();
    expRdQ.push_back(3'd0);
    sendByte({dev, 1'b1}, ack);
    chk(ack, "R1 ack read address", {15'd0, ack}, 16'h1);
    recvByte(rd, 1'b0);
    chk(rd == rdMem(3'd0), "R10 R7 read at reset pointer", {8'd0, rd}, {8'd0, rdMem(3'd0)});
    busStop();

    // write burst toggling within pair 2/3
    busStart();
    sendByte({dev, 1'b0}, ack);
    chk(ack, "R1 ack write address", {15'd0, ack}, 16'h1);
    sendByte(8'h03, ack);
    chk(ack, "R2 ack command", {15'd0, ack}, 16'h1);
    expWrQ.push_back({3'd3, 8'hA1});
    sendByte(8'hA1, ack);
    chk(ack, "R3 ack data 1", {15'd0, ack}, 16'h1);
    expWrQ.push_back({3'd2, 8'hB2});
    sendByte(8'hB2, ack);
    chk(ack, "R3 ack data 2", {15'd0, ack}, 16'h1);
    expWrQ.push_back({3'd3, 8'hC3});
    sendByte(8'hC3, ack);
    chk(ack, "R4 ack data 3", {15'd0, ack}, 16'h1);
    busStop();
    chk(expWrQ.size() == 0, "R4 burst writes seen", 16'(expWrQ.size()), 16'h0);

    // wrong address: no ack, no writes
    busStart();
    sendByte({7'h27, 1'b0}, ack);
    chk(!ack, "R1 no ack wrong address", {15'd0, ack}, 16'h0);
    sendByte(8'h00, ack);
    chk(!ack, "R1 no ack after mismatch", {15'd0, ack}, 16'h0);
    sendByte(8'h11, ack);
    chk(!ack, "R1 still released", {15'd0, ack}, 16'h0);
    busStop();

    // command upper bits ignored
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'hFC, ack);
    chk(ack, "R2 ack command FC", {15'd0, ack}, 16'h1);
    expWrQ.push_back({3'd4, 8'h55});
    sendByte(8'h55, ack);
    busStop();
    chk(expWrQ.size() == 0, "R2 write to reg 4", 16'(expWrQ.size()), 16'h0);

    // read with command and repeated start
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h06, ack);
    busStart();
    expRdQ.push_back(3'd6);
    expRdQ.push_back(3'd7);
    expRdQ.push_back(3'd6);
    sendByte({dev, 1'b1}, ack);
    chk(ack, "R5 ack read address", {15'd0, ack}, 16'h1);
    recvByte(rd, 1'b1);
    chk(rd == rdMem(3'd6), "R5 first read byte", {8'd0, rd}, {8'd0, rdMem(3'd6)});
    recvByte(rd, 1'b1);
    chk(rd == rdMem(3'd7), "R6 second read byte", {8'd0, rd}, {8'd0, rdMem(3'd7)});
    recvByte(rd, 1'b0);
    chk(rd == rdMem(3'd6), "R6 third read byte", {8'd0, rd}, {8'd0, rdMem(3'd6)});
    waitq(4);
    chk(sdaDriveLow == 1'b0, "R6 released after nack", {15'd0, sdaDriveLow}, 16'h0);
    recvByte(rd, 1'b0);
    chk(rd == 8'hFF, "R6 no data after nack", {8'd0, rd}, 16'h00FF);
    busStop();

    // read without command uses stored pointer 7
    busStart();
    expRdQ.push_back(3'd7);
    sendByte({dev, 1'b1}, ack);
    recvByte(rd, 1'b0);
    chk(rd == rdMem(3'd7), "R7 read at stored pointer", {8'd0, rd}, {8'd0, rdMem(3'd7)});
    busStop();

    // input pair capture
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h01, ack);
    busStart();
    expRdQ.push_back(3'd1);
    expRdQ.push_back(3'd0);
    sendByte({dev, 1'b1}, ack);
    recvByte(rd, 1'b1);
    chk(rd == rdMem(3'd1), "R9 input reg 1", {8'd0, rd}, {8'd0, rdMem(3'd1)});
    recvByte(rd, 1'b0);
    chk(rd == rdMem(3'd0), "R9 input reg 0", {8'd0, rd}, {8'd0, rdMem(3'd0)});
    busStop();

    // START in the middle of a data byte
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h02, ack);
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1);
    busStart();
    sendByte({dev, 1'b0}, ack);
    chk(ack, "R8 address after mid-byte start", {15'd0, ack}, 16'h1);
    sendByte(8'h05, ack);
    expWrQ.push_back({3'd5, 8'h77});
    sendByte(8'h77, ack);
    busStop();

    // STOP in the middle of a data byte
    busStart();
    sendByte({dev, 1'b0}, ack);
    sendByte(8'h06, ack);
    writeBit(1'b0); writeBit(1'b1); writeBit(1'b1); writeBit(1'b0);
    busStop();
    waitq(4);
    chk(sdaDriveLow == 1'b0, "R8 released after stop", {15'd0, sdaDriveLow}, 16'h0);

    // different strap value
    strap = 3'b000;
    dev = {4'b0100, strap};
    waitq(4);
    busStart();
    sendByte({dev, 1'b0}, ack);
    chk(ack, "R1 ack with new strap", {15'd0, ack}, 16'h1);
    sendByte(8'h00, ack);
    expWrQ.push_back({3'd0, 8'h9E});
    sendByte(8'h9E, ack);
    busStop();
    waitq(10);

    chk(expWrQ.size() == 0, "R3 all writes seen", 16'(expWrQ.size()), 16'h0);
    chk(expRdQ.size() == 0, "R5 all reads seen", 16'(expRdQ.size()), 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule